// File: doc/BRIEF.md
# Padded-Lane Partitioned SIMD Adder

This block adds two 32-bit operand words as a set of independent lanes. A two-bit mode input selects the layout: one 11-bit lane, two 11-bit lanes, or four 5-bit lanes. Each lane starts on a power-of-two slot boundary, which is bit 0, 8, 16 or 24. Because of this, operand bits reach their lane by plain wiring and need no compaction. The lanes are narrower than their slots, so each slot has padding above its lane.

The carry chain is cut at the lowest bit of every active lane, and a lane's carry out is discarded. The carry-break positions of all modes together fall on nine irregular bit positions. The block decodes one case per mode rather than one per combination of breaks. It reports the active break positions on a partition-point output.

Some bits are unused in every layout: 15..13 and 31..29. These bits get no adder cell, and they are reported on a constant blanking mask. Sum bits that are padding in the current mode are forced to zero. The block is purely combinational and has no states. Its mode decoder is a single unique case over four named modes: ONE_WIDE, TWO_WIDE, FOUR_NARROW and RESERVED. There are no transitions.

Top module: `sadd_padded_lanes`

## Requirements
- R1: With lane_mode 00 (one wide lane), sum_word[10:0] equals (a_word[10:0] + b_word[10:0]) modulo 2^11.
- R2: With lane_mode 01 (two wide lanes), sum_word[10:0] and sum_word[26:16] each equal the modulo-2^11 sum of the matching operand bits. No carry passes from the low lane to the high lane.
- R3: With lane_mode 10 (four narrow lanes), sum_word[4:0], [12:8], [20:16] and [28:24] each equal the modulo-32 sum of the matching operand bits, with no carry between lanes.
- R4: Every sum_word bit outside the active lanes of the current mode is 0, whatever the operand values.
- R5: lane_mode 11 is reserved. In this mode sum_word is 0 and break_pts is 0.
- R6: break_pts bit i is 1 exactly when bit i is the top bit of an active lane, or the lowest bit of an active lane other than bit 0. The resulting values are: mode 00 sets bit 10 only (0x00000400). Mode 01 sets bits 10, 16 and 26 (0x04010400). Mode 10 sets bits 4, 8, 12, 16, 20, 24 and 28 (0x11111110).
- R7: blank_mask is 0xE000E000 (bits 15..13 and 31..29 set) in every mode, and sum_word is 0 on those bits in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | 32 | First operand word |
| b_word | input | 32 | Second operand word |
| lane_mode | input | 2 | Layout select: 00 one 11-bit lane, 01 two 11-bit lanes, 10 four 5-bit lanes, 11 reserved |
| sum_word | output | 32 | Lane-wise sums, with padding bits at zero |
| break_pts | output | 32 | Active carry-break positions for the current mode |
| blank_mask | output | 32 | Bits unused in every mode |

## Verification
The bench builds the block with its default parameters: wide lanes of 11 bits and narrow lanes of 5 bits in a 32-bit word. These defaults give exactly the nine break positions and the 0xE000E000 blanking pattern named in the requirements. All-ones and lane-top operand patterns force a carry out of every lane, so a missing cut would show up in the next lane or in the padding bits. Random operands in each of the four modes then exercise the adder cells on every bit that is live in any layout.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        MODE_ONE_WIDE    = 2'b00,
        MODE_TWO_WIDE    = 2'b01,
        MODE_FOUR_NARROW = 2'b10,
        MODE_RESERVED    = 2'b11
    } lane_mode_e;

    // Bits covered by nlanes lanes of width w, each starting at a slot boundary.
    function automatic logic [WORD_W-1:0] lane_bits(int nlanes, int w);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < WORD_W; j++) begin
                if (k < nlanes && j < w) m[k*(WORD_W/nlanes) + j] = 1'b1;
            end
        end
        return m;
    endfunction

    // Lowest bit of every lane.
    function automatic logic [WORD_W-1:0] lane_starts(int nlanes);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nlanes) m[k*(WORD_W/nlanes)] = 1'b1;
        end
        return m;
    endfunction

    // Top bit of every lane.
    function automatic logic [WORD_W-1:0] lane_tops(int nlanes, int w);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nlanes) m[k*(WORD_W/nlanes) + w - 1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sadd_mode_decode.sv
module sadd_mode_decode
    import sadd_pkg::*;
#(
    parameter int WIDE_W   = 11,
    parameter int NARROW_W = 5
) (
    input  logic [1:0]        mode_i,
    output logic [WORD_W-1:0] active_o,
    output logic [WORD_W-1:0] start_o,
    output logic [WORD_W-1:0] pts_o
);
    localparam logic [WORD_W-1:0] ACT_ONE  = lane_bits(1, WIDE_W);
    localparam logic [WORD_W-1:0] ACT_TWO  = lane_bits(2, WIDE_W);
    localparam logic [WORD_W-1:0] ACT_FOUR = lane_bits(4, NARROW_W);
    localparam logic [WORD_W-1:0] ST_ONE   = lane_starts(1);
    localparam logic [WORD_W-1:0] ST_TWO   = lane_starts(2);
    localparam logic [WORD_W-1:0] ST_FOUR  = lane_starts(4);
    localparam logic [WORD_W-1:0] BIT0     = {{(WORD_W-1){1'b0}}, 1'b1};
    localparam logic [WORD_W-1:0] PT_ONE   = (ST_ONE  & ~BIT0) | lane_tops(1, WIDE_W);
    localparam logic [WORD_W-1:0] PT_TWO   = (ST_TWO  & ~BIT0) | lane_tops(2, WIDE_W);
    localparam logic [WORD_W-1:0] PT_FOUR  = (ST_FOUR & ~BIT0) | lane_tops(4, NARROW_W);

    lane_mode_e mode_q;
    assign mode_q = lane_mode_e'(mode_i);

    always_comb begin
        unique case (mode_q)
            MODE_ONE_WIDE:    begin active_o = ACT_ONE;  start_o = ST_ONE;  pts_o = PT_ONE;  end
            MODE_TWO_WIDE:    begin active_o = ACT_TWO;  start_o = ST_TWO;  pts_o = PT_TWO;  end
            MODE_FOUR_NARROW: begin active_o = ACT_FOUR; start_o = ST_FOUR; pts_o = PT_FOUR; end
            MODE_RESERVED:    begin active_o = '0;       start_o = '0;      pts_o = '0;      end
            default:          begin active_o = '0;       start_o = '0;      pts_o = '0;      end
        endcase
    end

    // Break points only ever sit on live lane bits (R6).
    always_comb begin
        p_pts_in_lane_r6: assert ((pts_o & ~active_o) == '0)
            else $error("break point outside an active lane");
        p_start_in_lane_r6: assert ((start_o & ~active_o) == '0)
            else $error("lane start outside an active lane");
    end
endmodule

// File: rtl/sadd_lane_chain.sv
module sadd_lane_chain
    import sadd_pkg::*;
#(
    parameter logic [WORD_W-1:0] SKIP = '0
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] active_i,
    input  logic [WORD_W-1:0] start_i,
    output logic [WORD_W-1:0] sum_o
);
    logic [WORD_W-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (SKIP[i]) begin : g_blank
            logic unused_bits;
            assign unused_bits = a_i[i] ^ b_i[i] ^ active_i[i] ^ start_i[i];
            assign sum_o[i] = 1'b0;
            if (i < WORD_W - 1) begin : g_cz
                assign cy[i+1] = 1'b0;
            end
        end else begin : g_cell
            logic cin;
            assign cin = start_i[i] ? 1'b0 : cy[i];
            assign sum_o[i] = active_i[i] & (a_i[i] ^ b_i[i] ^ cin);
            if (i < WORD_W - 1) begin : g_co
                assign cy[i+1] = (a_i[i] & b_i[i]) | (cin & (a_i[i] ^ b_i[i]));
            end
        end
    end

    always_comb begin
        p_pad_zero_r4: assert ((sum_o & ~active_i) == '0)
            else $error("padding sum bit nonzero");
        p_blank_zero_r7: assert ((sum_o & SKIP) == '0)
            else $error("permanently blank sum bit nonzero");
    end
endmodule

// File: rtl/sadd_padded_lanes.sv
module sadd_padded_lanes
    import sadd_pkg::*;
#(
    parameter int WIDE_W   = 11,
    parameter int NARROW_W = 5
) (
    input  logic [31:0] a_word,
    input  logic [31:0] b_word,
    input  logic [1:0]  lane_mode,
    output logic [31:0] sum_word,
    output logic [31:0] break_pts,
    output logic [31:0] blank_mask
);
    localparam logic [WORD_W-1:0] USED =
        lane_bits(1, WIDE_W) | lane_bits(2, WIDE_W) | lane_bits(4, NARROW_W);
    localparam logic [WORD_W-1:0] BLANK = ~USED;
    localparam int HALF = WORD_W / 2;
    localparam int QTR  = WORD_W / 4;

    logic [WORD_W-1:0] active_m;
    logic [WORD_W-1:0] start_m;

    sadd_mode_decode #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dec (
        .mode_i   (lane_mode),
        .active_o (active_m),
        .start_o  (start_m),
        .pts_o    (break_pts)
    );

    sadd_lane_chain #(.SKIP(BLANK)) u_chain (
        .a_i      (a_word),
        .b_i      (b_word),
        .active_i (active_m),
        .start_i  (start_m),
        .sum_o    (sum_word)
    );

    assign blank_mask = BLANK;

    always_comb begin
        if (lane_mode == 2'b00) begin
            p_one_wide_r1: assert (sum_word[0 +: WIDE_W] == WIDE_W'(a_word[0 +: WIDE_W] + b_word[0 +: WIDE_W]))
                else $error("wide lane sum wrong");
        end
        if (lane_mode == 2'b01) begin
            p_two_wide_r2: assert (sum_word[HALF +: WIDE_W] == WIDE_W'(a_word[HALF +: WIDE_W] + b_word[HALF +: WIDE_W]))
                else $error("upper wide lane sum wrong");
        end
        if (lane_mode == 2'b10) begin
            p_narrow_lo_r3: assert (sum_word[QTR +: NARROW_W] == NARROW_W'(a_word[QTR +: NARROW_W] + b_word[QTR +: NARROW_W]))
                else $error("narrow lane sum wrong");
            p_narrow_hi_r3: assert (sum_word[3*QTR +: NARROW_W] == NARROW_W'(a_word[3*QTR +: NARROW_W] + b_word[3*QTR +: NARROW_W]))
                else $error("top narrow lane sum wrong");
        end
        if (lane_mode == 2'b11) begin
            p_reserved_zero_r5: assert (sum_word == '0 && break_pts == '0)
                else $error("reserved mode not quiet");
        end
    end
endmodule

// File: tb/sim_sadd_padded_lanes.sv
module sim_sadd_padded_lanes;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] a_word = '0, b_word = '0;
    logic [1:0]  lane_mode = 2'b00;
    logic [31:0] sum_word, break_pts, blank_mask;
    int checks = 0, fails = 0;

    sadd_padded_lanes u0 (.*);

    function automatic logic [31:0] add_lane(logic [31:0] r, logic [31:0] a, logic [31:0] b, int lo, int w);
        logic [31:0] m = (32'h1 << w) - 1;
        return r | (((((a >> lo) & m) + ((b >> lo) & m)) & m) << lo);
    endfunction

    function automatic logic [31:0] exp_sum(logic [31:0] a, logic [31:0] b, logic [1:0] m);
        logic [31:0] r = '0;
        case (m)
            2'b00: r = add_lane(r, a, b, 0, 11);
            2'b01: begin r = add_lane(r, a, b, 0, 11); r = add_lane(r, a, b, 16, 11); end
            2'b10: for (int k = 0; k < 4; k++) r = add_lane(r, a, b, 8*k, 5);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] exp_act(logic [1:0] m);
        case (m)
            2'b00: return 32'h0000_07FF;
            2'b01: return 32'h07FF_07FF;
            2'b10: return 32'h1F1F_1F1F;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_pts(logic [1:0] m);
        case (m)
            2'b00: return 32'h0000_0400;
            2'b01: return 32'h0401_0400;
            2'b10: return 32'h1111_1110;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h (a=%08h b=%08h mode=%0d)",
                     tag, act, exp, a_word, b_word, lane_mode);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [1:0] m);
        string st;
        @(posedge clk);
        #1;
        a_word = a; b_word = b; lane_mode = m;
        @(negedge clk);
        case (m)
            2'b00: st = "R1";
            2'b01: st = "R2";
            2'b10: st = "R3";
            default: st = "R5";
        endcase
        check(st, sum_word, exp_sum(a, b, m));
        check("R4", sum_word & ~exp_act(m), 32'h0);
        check(m == 2'b11 ? "R5" : "R6", break_pts, exp_pts(m));
        check("R7", blank_mask, 32'hE000_E000);
        check("R7", sum_word & 32'hE000_E000, 32'h0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        // initial state: zero operands in mode 00
        @(negedge clk);
        check("R1", sum_word, 32'h0);
        check("R6", break_pts, 32'h0000_0400);
        check("R7", blank_mask, 32'hE000_E000);
        // directed corner cases: carry out of every lane top
        for (int m = 0; m < 4; m++) begin
            apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'(m));
            apply(32'hFFFF_FFFF, 32'h0000_0001, 2'(m));
            apply(32'h0000_0001, 32'hFFFF_FFFF, 2'(m));
            apply(32'h1F1F_07FF, 32'h0101_0001, 2'(m));
            apply(32'h0000_0000, 32'h0000_0000, 2'(m));
        end
        // R2 isolation: low-lane carry must not reach bit 16
        apply(32'h0000_07FF, 32'h0000_0001, 2'b01);
        // R3 isolation: each narrow lane overflows
        apply(32'h1F1F_1F1F, 32'h0101_0101, 2'b10);
        // random stimulus in every mode
        for (int n = 0; n < 800; n++) begin
            apply($urandom(), $urandom(), 2'(n % 4));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule